// File: doc/BRIEF.md
# Outbound Address Window Translator

This block holds a small bank of outbound translation windows for a bus slave port. Each window pairs a naturally aligned source region with a translated base and a translation ID. A lookup address is compared against every implemented window at once. On a hit, the address is rebased into the target space, and the ID of the winning window is reported. The ID tells the transaction builder downstream whether the access is a configuration access or a memory/IO access.

Software programs the windows through a 32-bit register port. The first window is normally set up for the configuration region and the later ones for memory ranges. The window's source base, its implemented flag and its log2 size code share one register word. A lookup strobe produces a registered result one clock later.

Top module: `xlat_window_bank`

## Requirements
- R1: After reset every window is unimplemented, every register reads 0, `res_valid` and `res_hit` are low, and any lookup misses.
- R2: Window n has its registers at byte offset 0x800 + n*0x20, decoded from `cfg_addr[11:2]`. The offsets are: +0x0 low source word, +0x4 high source word, +0x8 low translated word, +0xC high translated word, +0x10 ID in bits [3:0] (upper bits read 0). A read returns data on `cfg_rdata` one clock after the `cfg_rd` strobe.
- R3: Offsets +0x14 to +0x1C of a window, and any address outside 0x800 to 0x8FF, read 0 and ignore writes. Such writes leave all window registers and all lookup results unchanged.
- R4: A window matches only when bit 0 of its low source word (implemented) is 1 and the lookup address equals the source base in every bit at or above the effective size code.
- R5: Bits [6:1] of the low source word hold the size code c, and a window spans 2^c bytes. Codes below 7 act as 7, since bits [6:0] of the base hold the flag and the code and are never compared.
- R6: On a hit, `res_addr` equals the 64-bit translated base plus the lookup address's offset inside the window. This is a true addition, with carries into the upper bits.
- R7: When several windows match, the lowest-numbered one provides the address and the ID.
- R8: On a miss, `res_hit`, `res_addr` and `res_id` are all 0.
- R9: `res_valid` is high exactly one clock after `lookup_valid`. With no strobe in the cycle before, `res_valid` and `res_hit` are low. Back-to-back strobes each give their own result.
- R10: `res_id` carries the winning window's ID field (0 = memory/IO, 1 = configuration).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 12 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one clock after cfg_rd |
| lookup_valid | input | 1 | Lookup strobe |
| lookup_addr | input | 64 | Address to translate |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | A window matched |
| res_addr | output | 64 | Translated address |
| res_id | output | 4 | Translation ID of the winning window |

## Verification
Three results are due one rising edge after their stimulus:
- A register read's data.
- A lookup's hit, address and ID.
- A register write's effect on a lookup issued in the next cycle.

The bench drives every strobe on a falling edge and samples on the following falling edge, half a period after the capturing edge, then withdraws the strobe. The idle behaviour of `res_valid` is sampled one further falling edge later. Sampling this way confirms that each result persists only for the cycle it belongs to.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int ADDR_W   = 64;
    localparam int WORD_W   = 32;
    localparam int CODE_W   = 6;
    localparam int ID_W     = 4;
    localparam int MIN_CODE = 7;
    localparam int STRIDE   = 32;

    typedef enum logic [2:0] {
        FLD_SRC_LO = 3'd0,
        FLD_SRC_HI = 3'd1,
        FLD_DST_LO = 3'd2,
        FLD_DST_HI = 3'd3,
        FLD_ID     = 3'd4
    } field_e;

    typedef struct packed {
        logic [WORD_W-1:0] src_lo;
        logic [WORD_W-1:0] src_hi;
        logic [WORD_W-1:0] dst_lo;
        logic [WORD_W-1:0] dst_hi;
        logic [ID_W-1:0]   id;
    } win_t;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] addr;
        logic [ID_W-1:0]   id;
    } result_t;

    // low-bit mask covering the window span (minimum span 2^MIN_CODE)
    function automatic logic [ADDR_W-1:0] span_mask(input logic [CODE_W-1:0] code);
        logic [6:0]        eff;
        logic [ADDR_W-1:0] one;
        one = {{(ADDR_W-1){1'b0}}, 1'b1};
        eff = (code < CODE_W'(MIN_CODE)) ? 7'(MIN_CODE) : {1'b0, code};
        return (one << eff) - one;
    endfunction

endpackage

// File: rtl/xlat_regfile.sv
module xlat_regfile
    import xlat_pkg::*;
#(
    parameter int                NUM_WIN  = 8,
    parameter int                CFG_AW   = 12,
    parameter logic [CFG_AW-1:0] REG_BASE = 12'h800
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_wr,
    input  logic                     cfg_rd,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [WORD_W-1:0]        cfg_wdata,
    output logic [WORD_W-1:0]        cfg_rdata,
    output win_t [NUM_WIN-1:0]       wins
);

    localparam int          IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam int unsigned BASE_I = 32'(REG_BASE);
    localparam int unsigned END_I  = BASE_I + NUM_WIN * STRIDE;

    logic [31:0]      addr_i;
    logic [31:0]      rel;
    logic             in_rng;
    logic [IDX_W-1:0] widx;
    field_e           fsel;
    logic [WORD_W-1:0] rd_word;

    assign addr_i = 32'(cfg_addr);
    assign rel    = addr_i - BASE_I;
    assign in_rng = (addr_i >= BASE_I) && (addr_i < END_I);
    assign widx   = IDX_W'(rel >> 5);
    assign fsel   = field_e'(3'(rel >> 2));

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_store
        logic sel;
        assign sel = cfg_wr && in_rng && (widx == IDX_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                wins[w] <= '0;
            end else if (sel) begin
                case (fsel)
                    FLD_SRC_LO: wins[w].src_lo <= cfg_wdata;
                    FLD_SRC_HI: wins[w].src_hi <= cfg_wdata;
                    FLD_DST_LO: wins[w].dst_lo <= cfg_wdata;
                    FLD_DST_HI: wins[w].dst_hi <= cfg_wdata;
                    FLD_ID:     wins[w].id     <= cfg_wdata[ID_W-1:0];
                    default:    ;
                endcase
            end
        end
    end

    always_comb begin
        rd_word = '0;
        if (in_rng) begin
            case (fsel)
                FLD_SRC_LO: rd_word = wins[widx].src_lo;
                FLD_SRC_HI: rd_word = wins[widx].src_hi;
                FLD_DST_LO: rd_word = wins[widx].dst_lo;
                FLD_DST_HI: rd_word = wins[widx].dst_hi;
                FLD_ID:     rd_word = {{(WORD_W-ID_W){1'b0}}, wins[widx].id};
                default:    rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rdata <= '0;
        end else if (cfg_rd) begin
            cfg_rdata <= rd_word;
        end
    end

endmodule

// File: rtl/xlat_window_cmp.sv
module xlat_window_cmp
    import xlat_pkg::*;
(
    input  logic [WORD_W-1:0] src_lo,
    input  logic [WORD_W-1:0] src_hi,
    input  logic [WORD_W-1:0] dst_lo,
    input  logic [WORD_W-1:0] dst_hi,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] xaddr
);

    logic              impl;
    logic [CODE_W-1:0] code;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] dest;

    assign impl  = src_lo[0];
    assign code  = src_lo[CODE_W:1];
    assign mask  = span_mask(code);
    assign base  = {src_hi, src_lo};
    assign dest  = {dst_hi, dst_lo};
    assign hit   = impl && ((addr & ~mask) == (base & ~mask));
    assign xaddr = dest + (addr & mask);

endmodule

// File: rtl/xlat_prio.sv
module xlat_prio
    import xlat_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic [NUM_WIN-1:0]             hit_vec,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] xaddr_arr,
    input  logic [NUM_WIN-1:0][ID_W-1:0]   id_arr,
    output result_t                        pick
);

    always_comb begin
        pick = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                pick.hit  = 1'b1;
                pick.addr = xaddr_arr[i];
                pick.id   = id_arr[i];
            end
        end
    end

endmodule

// File: rtl/xlat_window_bank.sv
module xlat_window_bank
    import xlat_pkg::*;
#(
    parameter int                NUM_WIN  = 8,
    parameter int                CFG_AW   = 12,
    parameter logic [CFG_AW-1:0] REG_BASE = 12'h800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic              lookup_valid,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [ADDR_W-1:0] res_addr,
    output logic [ID_W-1:0]   res_id
);

    win_t [NUM_WIN-1:0]             wins;
    logic [NUM_WIN-1:0]             hit_vec;
    logic [NUM_WIN-1:0][ADDR_W-1:0] xaddr_arr;
    logic [NUM_WIN-1:0][ID_W-1:0]   id_arr;
    result_t                        pick;
    result_t                        res_q;
    logic                           vld_q;

    xlat_regfile #(
        .NUM_WIN (NUM_WIN),
        .CFG_AW  (CFG_AW),
        .REG_BASE(REG_BASE)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_rd   (cfg_rd),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .wins     (wins)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        xlat_window_cmp u_cmp (
            .src_lo(wins[w].src_lo),
            .src_hi(wins[w].src_hi),
            .dst_lo(wins[w].dst_lo),
            .dst_hi(wins[w].dst_hi),
            .addr  (lookup_addr),
            .hit   (hit_vec[w]),
            .xaddr (xaddr_arr[w])
        );
        assign id_arr[w] = wins[w].id;
    end

    xlat_prio #(.NUM_WIN(NUM_WIN)) u_prio (
        .hit_vec  (hit_vec),
        .xaddr_arr(xaddr_arr),
        .id_arr   (id_arr),
        .pick     (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= lookup_valid;
            res_q <= lookup_valid ? pick : '0;
        end
    end

    assign res_valid = vld_q;
    assign res_hit   = res_q.hit;
    assign res_addr  = res_q.addr;
    assign res_id    = res_q.id;

endmodule

// File: rtl/xlat_window_chk.sv
module xlat_window_chk
    import xlat_pkg::*;
#(
    parameter int                NUM_WIN  = 8,
    parameter int                CFG_AW   = 12,
    parameter logic [CFG_AW-1:0] REG_BASE = 12'h800
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_rd,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [WORD_W-1:0] cfg_rdata,
    input logic              lookup_valid,
    input logic              res_valid,
    input logic              res_hit,
    input logic [ADDR_W-1:0] res_addr,
    input logic [ID_W-1:0]   res_id
);

    localparam int unsigned BASE_I = 32'(REG_BASE);
    localparam int unsigned END_I  = BASE_I + NUM_WIN * STRIDE;

    logic [31:0] a32;
    logic        unmapped;
    assign a32      = 32'(cfg_addr);
    assign unmapped = (a32 < BASE_I) || (a32 >= END_I) ||
                      (((a32 - BASE_I) & 32'h1c) >= 32'h14);

    // R9
    res_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        lookup_valid |=> res_valid);

    // R9
    res_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lookup_valid |=> (!res_valid && !res_hit));

    // R9
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> res_valid);

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !res_hit |-> (res_addr == '0 && res_id == '0));

    // R3
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd && unmapped) |=> (cfg_rdata == '0));

endmodule

bind xlat_window_bank xlat_window_chk #(
    .NUM_WIN (NUM_WIN),
    .CFG_AW  (CFG_AW),
    .REG_BASE(REG_BASE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_rd      (cfg_rd),
    .cfg_addr    (cfg_addr),
    .cfg_rdata   (cfg_rdata),
    .lookup_valid(lookup_valid),
    .res_valid   (res_valid),
    .res_hit     (res_hit),
    .res_addr    (res_addr),
    .res_id      (res_id)
);

// File: tb/test_xlat_window_bank.sv
`timescale 1ns/1ps
module test_xlat_window_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lookup_valid = 1'b0;
    logic [63:0] lookup_addr = '0;
    logic        res_valid;
    logic        res_hit;
    logic [63:0] res_addr;
    logic [3:0]  res_id;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    xlat_window_bank i_xlat_window_bank (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
        .res_valid(res_valid), .res_hit(res_hit),
        .res_addr(res_addr), .res_id(res_id)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = a;
        @(negedge clk);
        d = cfg_rdata;
        cfg_rd = 1'b0;
    endtask

    task automatic look(input string req, input logic [63:0] a, input logic eh,
                        input logic [63:0] ea, input logic [3:0] eid);
        @(negedge clk);
        lookup_valid = 1'b1; lookup_addr = a;
        @(negedge clk);
        chk(req, "res_valid", 64'(res_valid), 64'd1);
        chk(req, "res_hit", 64'(res_hit), 64'(eh));
        chk(req, "res_addr", res_addr, ea);
        chk(req, "res_id", 64'(res_id), 64'(eid));
        lookup_valid = 1'b0;
    endtask

    function automatic logic [11:0] ra(input int w, input int off);
        return 12'(32'h800 + w * 32 + off);
    endfunction

    // R1: reset state
    task automatic t_reset();
        logic [31:0] d;
        chk("R1", "res_valid", 64'(res_valid), 64'd0);
        chk("R1", "res_hit", 64'(res_hit), 64'd0);
        rd(ra(0, 0), d);  chk("R1", "w0 src_lo", 64'(d), 64'd0);
        rd(ra(7, 16), d); chk("R1", "w7 id", 64'(d), 64'd0);
        look("R1", 64'h0, 1'b0, 64'h0, 4'h0);
        look("R1", 64'hffff_ffff_ffff_ff00, 1'b0, 64'h0, 4'h0);
    endtask

    // R2: register map and readback
    task automatic t_regmap();
        logic [31:0] d;
        wr(ra(3, 0), 32'hdead_be00);
        wr(ra(3, 4), 32'h1234_5678);
        wr(ra(3, 8), 32'hcafe_f00d);
        wr(ra(3, 12), 32'h0bad_c0de);
        wr(ra(3, 16), 32'hffff_fff1);
        rd(ra(3, 0), d);  chk("R2", "w3 +0", 64'(d), 64'hdead_be00);
        rd(ra(3, 4), d);  chk("R2", "w3 +4", 64'(d), 64'h1234_5678);
        rd(ra(3, 8), d);  chk("R2", "w3 +8", 64'(d), 64'hcafe_f00d);
        rd(ra(3, 12), d); chk("R2", "w3 +C", 64'(d), 64'h0bad_c0de);
        rd(ra(3, 16), d); chk("R2", "w3 +10", 64'(d), 64'h1);
        rd(ra(2, 0), d);  chk("R2", "w2 untouched", 64'(d), 64'h0);
        wr(ra(3, 0), 32'h0);
    endtask

    // R3: unmapped offsets
    task automatic t_unmapped();
        logic [31:0] d;
        wr(ra(0, 20), 32'hffff_ffff);
        wr(12'h900, 32'hffff_ffff);
        wr(12'h7fc, 32'hffff_ffff);
        rd(ra(0, 20), d); chk("R3", "w0 +14", 64'(d), 64'h0);
        rd(12'h900, d);   chk("R3", "0x900", 64'(d), 64'h0);
        rd(12'h7fc, d);   chk("R3", "0x7fc", 64'(d), 64'h0);
        rd(ra(0, 0), d);  chk("R3", "w0 src_lo kept", 64'(d), 64'h0);
        rd(ra(1, 0), d);  chk("R3", "w1 src_lo kept", 64'(d), 64'h0);
        look("R3", 64'hffff_ffff_ffff_ff80, 1'b0, 64'h0, 4'h0);
    endtask

    // R4 R6 R10: config window and a memory window
    task automatic t_basic();
        wr(ra(0, 0), 32'h4000_0039);  // base low, code 28, implemented
        wr(ra(0, 4), 32'h9);
        wr(ra(0, 16), 32'h1);
        look("R4", 64'h9_4012_3456, 1'b1, 64'h0012_3456, 4'h1);
        look("R10", 64'h9_4fff_fffc, 1'b1, 64'h0fff_fffc, 4'h1);
        look("R4", 64'h9_5000_0000, 1'b0, 64'h0, 4'h0);
        wr(ra(2, 0), 32'h3000_0029);  // code 20
        wr(ra(2, 8), 32'h8000_0000);
        wr(ra(2, 12), 32'h10);
        look("R6", 64'h300f_fff0, 1'b1, 64'h10_800f_fff0, 4'h0);
        look("R8", 64'h3010_0000, 1'b0, 64'h0, 4'h0);
    endtask

    // R4: implemented flag
    task automatic t_impl();
        wr(ra(4, 0), 32'h5000_0028);
        look("R4", 64'h5000_0100, 1'b0, 64'h0, 4'h0);
        wr(ra(4, 0), 32'h5000_0029);
        look("R4", 64'h5000_0100, 1'b1, 64'h100, 4'h0);
    endtask

    // R7: overlapping windows
    task automatic t_prio();
        wr(ra(5, 0), 32'h3000_0031);  // code 24 covers window 2
        wr(ra(5, 16), 32'h1);
        look("R7", 64'h3000_0010, 1'b1, 64'h10_8000_0010, 4'h0);
        look("R7", 64'h3080_0000, 1'b1, 64'h80_0000, 4'h1);
        wr(ra(2, 0), 32'h3000_0028);  // drop window 2
        look("R7", 64'h3000_0010, 1'b1, 64'h10, 4'h1);
    endtask

    // R5 R6: small code acts as 7, additive translation
    task automatic t_small();
        wr(ra(6, 0), 32'h7000_0005);  // code 2
        wr(ra(6, 8), 32'h1f0);
        look("R5", 64'h7000_007c, 1'b1, 64'h26c, 4'h0);
        look("R5", 64'h7000_0080, 1'b0, 64'h0, 4'h0);
    endtask

    // R9: timing, back-to-back and idle
    task automatic t_timing();
        @(negedge clk);
        lookup_valid = 1'b1; lookup_addr = 64'h9_4000_0004;
        @(negedge clk);
        chk("R9", "first hit", 64'(res_hit), 64'd1);
        chk("R9", "first addr", res_addr, 64'h4);
        lookup_addr = 64'h7000_0000;
        @(negedge clk);
        chk("R9", "second valid", 64'(res_valid), 64'd1);
        chk("R9", "second addr", res_addr, 64'h1f0);
        lookup_valid = 1'b0;
        @(negedge clk);
        chk("R9", "idle valid", 64'(res_valid), 64'd0);
        chk("R9", "idle hit", 64'(res_hit), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_unmapped();
        t_basic();
        t_impl();
        t_prio();
        t_small();
        t_timing();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule